// File: doc/BRIEF.md
# Two-wire bus register-access target

This block is the target side of a two-wire serial bus (I2C) placed in front of a small register file. It samples the clock and data lines on a much faster system clock and finds START, repeated START and STOP conditions in those samples. It recognises its own device address, takes a register pointer, and then moves bytes between the bus and a simple register port. That port has an address, write data, a one-cycle write strobe, read data and a one-cycle read strobe. On the bus the block only ever pulls the data line low, for acknowledges and for zero bits of read data.

A transfer starts with an address byte. Its upper seven bits name the device, and the two lowest of those seven come from strap pins, so several devices can share one bus. A write transfer then carries a pointer byte followed by any number of data bytes, which land at consecutive register addresses. A read transfer returns bytes from the pointer onward. A write that sets only the pointer, followed by a repeated START and a read, is the usual way to read from a chosen register.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the data-line pull output is 0 (line released) and both register strobes are 0.
- R2: A STOP (data rising while clock is high) at any bit position aborts the transfer. A byte cut short by it causes no write strobe, and later bytes get no acknowledge until a new START.
- R3: A STOP that falls within the same clock-high phase as the START before it is ignored, and the address byte that follows is still received and acknowledged.
- R4: The address byte is taken MSB first. Bits 7:1 must equal binary 10010 followed by strap bit 1 and strap bit 0. Bit 0 is read/write, where 1 means read. On a match the target pulls data low for the whole high phase of the 9th clock.
- R5: On an address mismatch the pull output stays 0 for the rest of the transfer, until the next START or STOP.
- R6: In a write, the byte after the address is the pointer. Bits 7:1 become the 7-bit register address, bit 0 is ignored, and the byte is acknowledged.
- R7: Each later write byte is acknowledged and produces exactly one single-cycle write strobe, with address equal to the pointer and data equal to the byte. The pointer then increments, wrapping from 127 to 0. The two strobes are never high together.
- R8: In a read, bytes are shifted out MSB first starting at the pointer. Each byte is fetched with exactly one single-cycle read strobe, during which the pull output is 0, and the pointer increments after each byte.
- R9: A master NACK on the 9th clock of a read byte ends the read, and the pull output stays 0 until the next START or STOP.
- R10: A repeated START keeps the pointer set earlier in the same bus session.
- R11: The pull output changes only while the clock line is low. This holds when the system clock runs at least 8 times the bus clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two bits of the device address |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr_o | output | 7 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_re_o | output | 1 | Single-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, sampled while reg_re_o is high |

## Verification
On every cycle the assertions check four things. The pull output moves only while the clock line is low. Write and read strobes are single pulses that never overlap. The data line is released during a read fetch. Other behaviour can only be shown through bus scenarios in the bench: address matching against the straps, pointer decoding, auto-increment and its wrap at 127, the effect of a NACK, aborts by STOP in mid-byte, an early STOP in the START's own high phase, and a pointer kept across a repeated START. The bench checks these against its own model of the register contents.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int REG_AW = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
        logic                   start_hi;
    } smp_t;

    smp_t q, d;
    logic [SYNC_STAGES-1:0] scl_shift, sda_shift;
    logic scl_cur, sda_cur, stop_raw;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign scl_shift = {q.scl_sync[SYNC_STAGES-2:0], scl_i};
            assign sda_shift = {q.sda_sync[SYNC_STAGES-2:0], sda_i};
        end else begin : g_single
            assign scl_shift = scl_i;
            assign sda_shift = sda_i;
        end
    endgenerate

    assign scl_cur    = q.scl_sync[SYNC_STAGES-1];
    assign sda_cur    = q.sda_sync[SYNC_STAGES-1];
    assign scl_rise_o = scl_cur & ~q.scl_prev;
    assign scl_fall_o = ~scl_cur & q.scl_prev;
    assign start_o    = scl_cur & q.scl_prev & q.sda_prev & ~sda_cur;
    assign stop_raw   = scl_cur & q.scl_prev & ~q.sda_prev & sda_cur;
    assign stop_o     = stop_raw & ~q.start_hi;
    assign scl_lvl_o  = scl_cur;
    assign sda_lvl_o  = sda_cur;

    always_comb begin
        d          = q;
        d.scl_sync = scl_shift;
        d.sda_sync = sda_shift;
        d.scl_prev = scl_cur;
        d.sda_prev = sda_cur;
        if (start_o) begin
            d.start_hi = 1'b1;
        end else if (scl_fall_o) begin
            d.start_hi = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_sync <= '1;
            q.sda_sync <= '1;
            q.scl_prev <= 1'b1;
            q.sda_prev <= 1'b1;
            q.start_hi <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b10010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [1:0]        strap_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              pull_o,
    output logic [REG_AW-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              re_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shift;
        logic [REG_AW-1:0]  ptr;
        logic               rw;
        logic               nack;
        logic               we;
        logic               re;
        logic [BYTE_W-1:0]  wdata;
        logic               pull;
    } fsm_t;

    fsm_t q, d;
    logic rx_bit, byte_end, is_ack_st;

    assign rx_bit   = scl_rise_i && (q.cnt < FULL);
    assign byte_end = scl_fall_i && (q.cnt == FULL);

    always_comb begin
        d    = q;
        d.we = 1'b0;
        d.re = 1'b0;
        if (start_i) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
        end else if (stop_i) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (rx_bit) begin
                        d.shift = {q.shift[BYTE_W-2:0], sda_lvl_i};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (byte_end) begin
                        d.cnt = '0;
                        if (q.state == ST_ADDR) begin
                            if (q.shift[7:1] == {DEV_PREFIX, strap_i}) begin
                                d.rw    = q.shift[0];
                                d.state = ST_ADDR_ACK;
                            end else begin
                                d.state = ST_SKIP;
                            end
                        end else if (q.state == ST_PTR) begin
                            d.ptr   = q.shift[7:1];
                            d.state = ST_PTR_ACK;
                        end else begin
                            d.we    = 1'b1;
                            d.wdata = q.shift;
                            d.state = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        if (q.rw) begin
                            d.state = ST_RDATA;
                            d.re    = 1'b1;
                        end else begin
                            d.state = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall_i) d.state = ST_WDATA;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall_i) begin
                        d.ptr   = q.ptr + 1'b1;
                        d.state = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (q.re) begin
                        d.shift = rdata_i;
                    end
                    if (scl_rise_i && (q.cnt < FULL)) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (byte_end) begin
                        d.cnt   = '0;
                        d.ptr   = q.ptr + 1'b1;
                        d.state = ST_RDATA_ACK;
                    end else if (scl_fall_i) begin
                        d.shift = {q.shift[BYTE_W-2:0], 1'b1};
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise_i) begin
                        d.nack = sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (q.nack) begin
                            d.state = ST_SKIP;
                        end else begin
                            d.state = ST_RDATA;
                            d.re    = 1'b1;
                        end
                    end
                end
                ST_IDLE, ST_SKIP: begin
                    d.cnt = '0;
                end
                default: d.state = ST_IDLE;
            endcase
        end
        is_ack_st = (d.state == ST_ADDR_ACK) || (d.state == ST_PTR_ACK) ||
                    (d.state == ST_WDATA_ACK);
        d.pull = is_ack_st ||
                 ((d.state == ST_RDATA) && !d.re && !d.shift[BYTE_W-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.shift <= '1;
            q.ptr   <= '0;
            q.rw    <= 1'b0;
            q.nack  <= 1'b0;
            q.we    <= 1'b0;
            q.re    <= 1'b0;
            q.wdata <= '0;
            q.pull  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pull_o  = q.pull;
    assign addr_o  = q.ptr;
    assign wdata_o = q.wdata;
    assign we_o    = q.we;
    assign re_o    = q.re;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX  = 5'b10010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_pull_o,
    output logic [REG_AW-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_PREFIX(DEV_PREFIX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl_i (sda_lvl),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .strap_i   (strap_i),
        .rdata_i   (reg_rdata_i),
        .pull_o    (sda_pull_o),
        .addr_o    (reg_addr_o),
        .wdata_o   (reg_wdata_o),
        .we_o      (reg_we_o),
        .re_o      (reg_re_o)
    );

    logic unused_lvl;
    assign unused_lvl = scl_lvl;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_pull_o,
    input logic reg_we_o,
    input logic reg_re_o
);
    // R7: strobes never overlap
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_o && reg_re_o));

    // R7: write strobe lasts one cycle
    p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R8: read strobe lasts one cycle
    p_re_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |=> !reg_re_o);

    // R8: line released while a byte is fetched
    p_re_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |-> !sda_pull_o);

    // R11: pull output moves only with the clock line low
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_pull_o(sda_pull_o),
    .reg_we_o  (reg_we_o),
    .reg_re_o  (reg_re_o)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
    localparam int H = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_pull, we, re;
    logic [6:0] addr;
    logic [7:0] wdata, rdata;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int pull_cnt = 0;

    logic [7:0] regs [128];
    logic [7:0] exp_mem [128];
    logic [7:0] pay [8];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign rdata   = regs[addr];

    i2c_reg_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .reg_addr_o (addr),
        .reg_wdata_o(wdata),
        .reg_we_o   (we),
        .reg_re_o   (re),
        .reg_rdata_i(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) regs[i] <= 8'(i * 7 + 3);
        end else if (we) begin
            regs[addr] <= wdata;
        end
    end

    always @(posedge clk) begin
        if (we) we_cnt <= we_cnt + 1;
        if (re) re_cnt <= re_cnt + 1;
        if (sda_pull) pull_cnt <= pull_cnt + 1;
    end

    function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic rd);
        return {5'b10010, s, rd};
    endfunction

    function automatic logic [6:0] next_ptr(input logic [6:0] p);
        return p + 7'd1;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        tick(2); sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bstop();
        tick(2); sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        tick(2); sda_m = b; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(2); sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        ack = ~sda_bus;
        tick(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(H + 2);
            scl_m = 1'b1; tick(H / 2);
            b = {b[6:0], sda_bus};
            tick(H / 2);
            scl_m = 1'b0;
        end
        tick(2); sda_m = ~mack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
        tick(2); sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] p, input int n, input logic pbit0);
        logic ack;
        logic [6:0] cur;
        int w0;
        w0 = we_cnt;
        bstart();
        send_byte(dev_byte(strap, 1'b0), ack);
        chk(ack, "R4 address ack", ack, 1);
        send_byte({p, pbit0}, ack);
        chk(ack, "R6 pointer ack", ack, 1);
        cur = p;
        for (int i = 0; i < n; i++) begin
            send_byte(pay[i], ack);
            chk(ack, "R7 data ack", ack, 1);
            exp_mem[cur] = pay[i];
            cur = next_ptr(cur);
        end
        bstop();
        chk(we_cnt - w0 == n, "R7 write strobe count", we_cnt - w0, n);
    endtask

    task automatic rd_txn(input logic [6:0] p, input int n);
        logic ack;
        logic [7:0] b;
        logic [6:0] cur;
        int r0;
        bstart();
        send_byte(dev_byte(strap, 1'b0), ack);
        send_byte({p, 1'b0}, ack);
        bstart();
        send_byte(dev_byte(strap, 1'b1), ack);
        chk(ack, "R4 read address ack", ack, 1);
        r0 = re_cnt;
        cur = p;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == exp_mem[cur], "R8 R10 read data", b, exp_mem[cur]);
            cur = next_ptr(cur);
        end
        chk(re_cnt - r0 == n, "R8 read strobe count", re_cnt - r0, n);
        bstop();
    endtask

    initial begin
        int pc;
        logic ack;
        logic [7:0] b;
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 7 + 3);
        tick(5);
        chk(sda_pull == 1'b0 && we == 1'b0 && re == 1'b0, "R1 reset outputs",
            {sda_pull, we, re}, 0);
        rst_n = 1'b1;
        tick(5);
        chk(sda_pull == 1'b0, "R1 idle after reset", sda_pull, 0);

        // R6: pointer bit 0 ignored
        pay[0] = 8'hA5;
        wr_txn(7'd10, 1, 1'b1);
        chk(regs[10] == 8'hA5, "R6 pointer bits 7:1", regs[10], 8'hA5);

        // R7: auto-increment across 127 -> 0
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
        wr_txn(7'd126, 3, 1'b0);
        chk(regs[126] == 8'h11 && regs[127] == 8'h22 && regs[0] == 8'h33,
            "R7 wrap write", regs[0], 8'h33);

        // R8 R10: read back across wrap via repeated START
        rd_txn(7'd126, 3);

        // R5: wrong address, no pull for the rest of the transfer
        pc = pull_cnt;
        bstart();
        send_byte(dev_byte(~strap, 1'b0), ack);
        chk(!ack, "R5 mismatch no ack", ack, 0);
        send_byte(8'h20, ack);
        send_byte(8'h5A, ack);
        bstop();
        chk(pull_cnt == pc, "R5 no pull after mismatch", pull_cnt - pc, 0);
        chk(regs[16] == exp_mem[16], "R5 no write after mismatch", regs[16], exp_mem[16]);

        // R9: NACK ends read; extra clocked byte sees released line
        bstart();
        send_byte(dev_byte(strap, 1'b0), ack);
        send_byte({7'd10, 1'b0}, ack);
        bstart();
        send_byte(dev_byte(strap, 1'b1), ack);
        recv_byte(1'b0, b);
        chk(b == exp_mem[10], "R9 byte before nack", b, exp_mem[10]);
        pc = pull_cnt;
        recv_byte(1'b0, b);
        chk(b == 8'hFF && pull_cnt == pc, "R9 released after nack", b, 8'hFF);
        bstop();

        // R2: STOP in mid byte aborts, no write strobe
        pc = we_cnt;
        bstart();
        send_byte(dev_byte(strap, 1'b0), ack);
        send_byte({7'd40, 1'b0}, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bstop();
        chk(we_cnt == pc, "R2 abort no write", we_cnt - pc, 0);
        pc = pull_cnt;
        send_byte(dev_byte(strap, 1'b0), ack);
        chk(!ack && pull_cnt == pc, "R2 no ack without START", ack, 0);

        // R3: STOP in the same high phase as START is ignored
        tick(2); sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b0;
        send_byte(dev_byte(strap, 1'b0), ack);
        chk(ack, "R3 early stop ignored", ack, 1);
        bstop();

        // random mixed writes and reads with varying straps
        for (int it = 0; it < 12; it++) begin
            int n;
            logic [6:0] p;
            strap = 2'($urandom);
            p = 7'($urandom);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
            wr_txn(p, n, 1'($urandom));
            rd_txn(p, n);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule